// File: doc/BRIEF.md
# Incremental Integrator Cell

This block is one integrating cell of an incremental differential-equation engine. Every quantity that enters or leaves the cell is a signed change of exactly one least-significant unit. Each change travels on a two-wire code. The cell keeps two registers of `WIDTH` bits each: an integrand `y` and an integral accumulator `S`, both in two's complement. On every integration step, `y` first takes in the increments of up to two integrand inputs. Then, depending on the sign of the independent-variable increment `dx`, the cell adds `y` to `S`, subtracts it, or leaves `S` alone.

When the accumulator leaves its signed range, the wrap-around becomes a one-unit output increment `dS`. This scales the integral by 2^-WIDTH. A per-step inversion flag reverses the sign of that output increment. A load port presets `y` and `S` before a run. A step strobe advances the cell by one step. The two integrand increments are applied one after the other inside the step: `y` plus the first, then that result plus the second.

Top module: `dda_integrator`

## Requirements
- R1: After reset, `ds_o` is 00, and `y` and `S` both start at zero.
- R2: The increment code on every two-wire input and on the output is as follows. 10 means +1 and 01 means −1. 00 means no change, and on inputs 11 is also read as no change.
- R3: On a step, `y` becomes `y + dy_a + dy_b`, wrapping modulo 2^WIDTH. The new `y` is the one used by the same step. When both integrand inputs carry no change, `y` holds.
- R4: On a step, `dx` = +1 adds the updated `y` to `S` and `dx` = −1 subtracts it. When `dx` carries no change, `S` holds. The result wraps modulo 2^WIDTH.
- R5: On a step, a true result above 2^(WIDTH−1)−1 produces an output code of 10, and the stored `S` is then negative. A true result below −2^(WIDTH−1) produces 01. Any other result produces 00.
- R6: When `invert_i` is high during a step, the output code of that step has its sign reversed: 10 becomes 01 and 01 becomes 10.
- R7: A cycle with `load_i` high writes `load_y_i` into `y` and `load_s_i` into `S`. That cycle takes priority over a step in the same cycle, and it produces output code 00.
- R8: `ds_o` carries a step's code in the cycle right after the step strobe. In every other cycle it is 00.
- R9: Start from `S` = −2^(WIDTH−1) with a constant `y` = k > 0, and apply N steps of `dx` = +1. The number of +1 outputs is then floor(N·k / 2^WIDTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Preset strobe for both registers |
| load_y_i | input | WIDTH | Preset value for the integrand `y` |
| load_s_i | input | WIDTH | Preset value for the accumulator `S` |
| step_i | input | 1 | Integration step strobe |
| dx_i | input | 2 | Independent-variable increment code |
| dy_a_i | input | 2 | First integrand increment code |
| dy_b_i | input | 2 | Second integrand increment code |
| invert_i | input | 1 | Reverse the sign of this step's output increment |
| ds_o | output | 2 | Output integral increment code |

## Verification
The bench builds the cell with `WIDTH` = 4. At that width it can preset every pair of `y` and `S` values and combine each pair with all four `dx` codes and both inversion settings. This drives every overflow boundary in both directions, including the subtraction of the most negative `y`. A long pseudo-random run then uses both integrand inputs and the illegal code 11, starting from the reset state. The bench predicts each output from an unbounded integer running total, using floor division by 2^WIDTH. Constant-integrand runs then check the total pulse count for every positive `k` the width allows.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [1:0] {
    INC_NONE = 2'b00,
    INC_DN   = 2'b01,
    INC_UP   = 2'b10,
    INC_BAD  = 2'b11
  } incr_e;

  // Two-wire code to a signed value of -1, 0 or +1.
  function automatic logic signed [1:0] incr_value(logic [1:0] code);
    case (incr_e'(code))
      INC_UP:  return 2'sd1;
      INC_DN:  return -2'sd1;
      default: return 2'sd0;
    endcase
  endfunction

  // Signed value back to the two-wire code.
  function automatic logic [1:0] incr_code(logic signed [1:0] v);
    if (v > 2'sd0)      return INC_UP;
    else if (v < 2'sd0) return INC_DN;
    else                return INC_NONE;
  endfunction

endpackage

// File: rtl/dda_incr_merge.sv
module dda_incr_merge
  import dda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic signed [WIDTH-1:0] load_val_i,
  input  logic                    step_i,
  input  logic [1:0]              dy_a_i,
  input  logic [1:0]              dy_b_i,
  output logic signed [WIDTH-1:0] y_next_o
);

  function automatic logic signed [WIDTH-1:0] grow(logic signed [1:0] v);
    return {{(WIDTH-2){v[1]}}, v};
  endfunction

  logic signed [WIDTH-1:0] y_q;
  logic signed [WIDTH-1:0] y_mid;   // after the first half-step
  logic signed [WIDTH-1:0] y_next;  // after the second half-step
  logic                    dy_idle;

  assign y_mid    = y_q + grow(incr_value(dy_a_i));
  assign y_next   = y_mid + grow(incr_value(dy_b_i));
  assign dy_idle  = (incr_value(dy_a_i) == 2'sd0) && (incr_value(dy_b_i) == 2'sd0);
  assign y_next_o = y_next;

  always_ff @(posedge clk) begin
    if (!rst_n)      y_q <= '0;
    else if (load_i) y_q <= load_val_i;
    else if (step_i) y_q <= y_next;
  end

  AST_Y_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dy_idle) |=> $stable(y_q)); // R3
  AST_Y_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (y_q == $past(load_val_i))); // R7

endmodule

// File: rtl/dda_int_accum.sv
module dda_int_accum
  import dda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic signed [WIDTH-1:0] load_val_i,
  input  logic                    step_i,
  input  logic [1:0]              dx_i,
  input  logic signed [WIDTH-1:0] y_i,
  output logic                    ovf_up_o,
  output logic                    ovf_dn_o
);

  localparam int EW = WIDTH + 2;
  localparam logic signed [EW-1:0] S_MAX = {{(EW-WIDTH+1){1'b0}}, {(WIDTH-1){1'b1}}};
  localparam logic signed [EW-1:0] S_MIN = ~S_MAX;

  function automatic logic signed [EW-1:0] widen(logic signed [WIDTH-1:0] v);
    return {{2{v[WIDTH-1]}}, v};
  endfunction

  logic signed [WIDTH-1:0] s_q;
  logic signed [EW-1:0]    wide_sum;
  logic                    dx_idle;

  always_comb begin
    case (incr_value(dx_i))
      2'sd1:   wide_sum = widen(s_q) + widen(y_i);
      -2'sd1:  wide_sum = widen(s_q) - widen(y_i);
      default: wide_sum = widen(s_q);
    endcase
  end

  assign dx_idle  = (incr_value(dx_i) == 2'sd0);
  assign ovf_up_o = (wide_sum > S_MAX);
  assign ovf_dn_o = (wide_sum < S_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n)      s_q <= '0;
    else if (load_i) s_q <= load_val_i;
    else if (step_i) s_q <= wide_sum[WIDTH-1:0];
  end

  AST_S_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (!step_i || dx_idle)) |=> $stable(s_q)); // R4
  AST_S_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (s_q == $past(load_val_i))); // R7
  AST_OVF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_up_o, ovf_dn_o})); // R5
  AST_UP_WRAPS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ovf_up_o) |=> s_q[WIDTH-1]); // R5

endmodule

// File: rtl/dda_out_stage.sv
module dda_out_stage
  import dda_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic       ovf_up_i,
  input  logic       ovf_dn_i,
  input  logic       invert_i,
  output logic [1:0] ds_o
);

  logic signed [1:0] raw_d;
  logic signed [1:0] out_d;
  logic [1:0]        ds_q;

  assign raw_d = ovf_up_i ? 2'sd1 : (ovf_dn_i ? -2'sd1 : 2'sd0);
  assign out_d = invert_i ? -raw_d : raw_d;

  always_ff @(posedge clk) begin
    if (!rst_n)      ds_q <= INC_NONE;
    else if (fire_i) ds_q <= incr_code(out_d);
    else             ds_q <= INC_NONE;
  end

  assign ds_o = ds_q;

  AST_UP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && ovf_up_i && !invert_i) |=> (ds_q == 2'b10)); // R5
  AST_UP_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && ovf_up_i && invert_i) |=> (ds_q == 2'b01)); // R6
  AST_DN_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && ovf_dn_i && invert_i) |=> (ds_q == 2'b10)); // R6

endmodule

// File: rtl/dda_integrator.sv
module dda_integrator
  import dda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_y_i,
  input  logic [WIDTH-1:0] load_s_i,
  input  logic             step_i,
  input  logic [1:0]       dx_i,
  input  logic [1:0]       dy_a_i,
  input  logic [1:0]       dy_b_i,
  input  logic             invert_i,
  output logic [1:0]       ds_o
);

  logic signed [WIDTH-1:0] y_cur;
  logic                    ovf_up;
  logic                    ovf_dn;
  logic                    step_fire;

  // A preset in the same cycle cancels the step.
  assign step_fire = step_i && !load_i;

  dda_incr_merge #(.WIDTH(WIDTH)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_y_i),
    .step_i     (step_i),
    .dy_a_i     (dy_a_i),
    .dy_b_i     (dy_b_i),
    .y_next_o   (y_cur)
  );

  dda_int_accum #(.WIDTH(WIDTH)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_s_i),
    .step_i     (step_i),
    .dx_i       (dx_i),
    .y_i        (y_cur),
    .ovf_up_o   (ovf_up),
    .ovf_dn_o   (ovf_dn)
  );

  dda_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (step_fire),
    .ovf_up_i (ovf_up),
    .ovf_dn_i (ovf_dn),
    .invert_i (invert_i),
    .ds_o     (ds_o)
  );

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> (ds_o == 2'b00)); // R8
  AST_NO_CODE11: assert property (@(posedge clk) disable iff (!rst_n)
    ds_o != 2'b11); // R2

endmodule

// File: tb/test_dda_integrator.sv
module test_dda_integrator;

  localparam int W = 4;
  localparam longint M = 64'sd16;
  localparam longint H = 64'sd8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] load_y_i = '0;
  logic [W-1:0] load_s_i = '0;
  logic         step_i = 1'b0;
  logic [1:0]   dx_i = 2'b00;
  logic [1:0]   dy_a_i = 2'b00;
  logic [1:0]   dy_b_i = 2'b00;
  logic         invert_i = 1'b0;
  logic [1:0]   ds_o;

  int     checks = 0;
  int     fails = 0;
  longint tot = 0;  // unbounded running integral
  longint yv = 0;   // integrand, signed W-bit value
  logic [1:0] last_ds;

  always #4 clk = ~clk;

  dda_integrator #(.WIDTH(W)) i_dda_integrator (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_y_i(load_y_i),
    .load_s_i(load_s_i), .step_i(step_i), .dx_i(dx_i), .dy_a_i(dy_a_i),
    .dy_b_i(dy_b_i), .invert_i(invert_i), .ds_o(ds_o)
  );

  function automatic longint fdiv(longint a, longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint wrapw(longint v);
    longint r;
    r = ((v % M) + M) % M;
    if (r >= H) r = r - M;
    return r;
  endfunction

  // R2: 10 -> +1, 01 -> -1, 00/11 -> 0
  function automatic longint val(logic [1:0] c);
    if (c == 2'b10) return 1;
    if (c == 2'b01) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] code(longint d);
    if (d > 0) return 2'b10;
    if (d < 0) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ds_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_load(longint ys, longint ss);
    @(negedge clk);
    load_i = 1'b1; load_y_i = ys[W-1:0]; load_s_i = ss[W-1:0];
    @(negedge clk);
    load_i = 1'b0;
    yv = wrapw(ys); tot = wrapw(ss);
  endtask

  task automatic do_step(logic [1:0] dx, logic [1:0] a, logic [1:0] b,
                         logic inv, string req);
    longint told, d;
    @(negedge clk);
    step_i = 1'b1; dx_i = dx; dy_a_i = a; dy_b_i = b; invert_i = inv;
    yv = wrapw(yv + val(a) + val(b));
    told = tot;
    tot = tot + val(dx) * yv;
    d = fdiv(tot + H, M) - fdiv(told + H, M);
    if (inv) d = -d;
    @(negedge clk);
    last_ds = ds_o;
    chk(req, ds_o, code(d));
    step_i = 1'b0; dx_i = 2'b00; dy_a_i = 2'b00; dy_b_i = 2'b00; invert_i = 1'b0;
    @(negedge clk);
    chk("R8 idle after step", ds_o, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset output", ds_o, 2'b00);

    // R1/R2/R3: pseudo-random run from reset state, both dy inputs, code 11
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_step(lf[1:0], lf[3:2], lf[5:4], lf[6], "R3 random dy/dx run");
    end

    // R4/R5/R6: every y, S, dx code and inversion setting
    for (int ys = 0; ys < 16; ys++)
      for (int ss = 0; ss < 16; ss++)
        for (int dc = 0; dc < 4; dc++)
          for (int iv = 0; iv < 2; iv++) begin
            do_load(longint'(ys), longint'(ss));
            do_step(dc[1:0], 2'b00, 2'b00, iv[0], "R5 sweep overflow");
          end

    // R7: load and step together -> load wins, no output
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      load_i = 1'b1; step_i = 1'b1; dx_i = 2'b10;
      load_y_i = 4'(k + 3); load_s_i = 4'(k * 5);
      @(negedge clk);
      chk("R7 load beats step", ds_o, 2'b00);
      load_i = 1'b0; step_i = 1'b0; dx_i = 2'b00;
      yv = wrapw(longint'(k + 3)); tot = wrapw(longint'(k * 5));
      for (int j = 0; j < 6; j++)
        do_step(2'b10, 2'b00, 2'b00, 1'b0, "R7 state after load");
    end

    // R9: constant integrand count
    for (int k = 1; k < 8; k++) begin
      do_load(longint'(k), -H);
      cnt = 0;
      for (int n = 0; n < 40; n++) begin
        do_step(2'b10, 2'b00, 2'b00, 1'b0, "R9 step");
        if (last_ds == 2'b10) cnt++;
      end
      checks++;
      if (cnt != (40 * k) / 16) begin
        fails++;
        $display("FAIL R9: k=%0d count=%0d expected %0d", k, cnt, (40 * k) / 16);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule